// File: doc/BRIEF.md
# Transaction Packet Routing Classifier

This block inspects the header of one received transaction-layer packet at a time and decides how it must travel. From the format/type byte it works out the packet's kind. It then picks one of three routing schemes: address, ID or implicit. It compares the packet's address or ID fields with the local settings and names a destination: the local function, the downstream side, the upstream side, or every downstream port. Configuration requests that cross onto the bridge's secondary bus are flagged for conversion from the forwarding form (Type 1) to the local form (Type 0).

Headers arrive over a valid/ready handshake. The classification is held in a registered output stage that is driven by a two-state machine:
- `ST_EMPTY`: no result is held.
- `ST_FULL`: a result is presented.

The transitions are:
- `ACCEPT`: from EMPTY to FULL.
- `PASS`: FULL to FULL, a result drains while a new header is taken in the same cycle.
- `HOLD`: FULL to FULL, stalled.
- `DRAIN`: FULL to EMPTY.
- `IDLE`: EMPTY to EMPTY.

The local settings are static inputs:
- the port's own 16-bit ID;
- a 64-bit memory window;
- a 32-bit I/O window;
- the secondary and subordinate bus numbers.

Top module: `tlp_route_classifier`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: The output fields use these encodings:
  - `out_scheme`: 0 address, 1 ID, 2 implicit.
  - `out_target`: 0 local, 1 downstream, 2 upstream, 3 broadcast.

  A header accepted on a clock edge (`in_valid` and `in_ready` both high) has its result on the outputs with `out_valid` high after that same edge. `in_ready` is high exactly when no result is held or `out_ready` is high. While `out_valid` is high and `out_ready` is low, every output stays unchanged.
- R3: `hdr_kind` is header byte 0, with fmt in bits [7:5] and type in bits [4:0]. A memory request has type 00000 or 00001. It uses address routing. When `hdr_kind[5]` is 1 the address is `{hdr_dw2, hdr_dw3}`; otherwise it is `hdr_dw2` zero-extended. The target is downstream when `mem_base <= addr <= mem_limit`, and upstream otherwise.
- R4: An I/O request (type 00010) uses address routing on `hdr_dw2`. The target is downstream when `io_base <= hdr_dw2 <= io_limit`, and upstream otherwise.
- R5: A local-form configuration request (type 00100) uses ID routing with target local and no conversion flag.
- R6: A forwarding-form configuration request (type 00101) uses ID routing on the bus number in `hdr_dw2[31:24]`:
  - bus equal to `sec_bus`: downstream, with `out_to_type0` set;
  - `sec_bus < bus <= sub_bus`: downstream, flag clear;
  - otherwise: upstream.
- R7: A completion (type 01010 or 01011) uses ID routing on `hdr_dw2[31:16]`:
  - equal to `own_id`: local;
  - bus byte in `[sec_bus, sub_bus]`: downstream;
  - otherwise: upstream.
- R8: A message has type 10ccc, where ccc is its routing code. Four codes use implicit routing:
  - code 000: upstream;
  - code 011: broadcast;
  - code 100: local;
  - code 101: upstream.
- R9: A message with code 001 is routed exactly as a memory request (R3). A message with code 010 is routed exactly as a completion (R7).
- R10: Each of the following is routed implicit to local with `out_err` set:
  - a message with code 110 or 111;
  - a header with `hdr_kind[7]` set;
  - a header with any type not listed in R3 to R9.

  `out_err` is 0 for every other header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header present |
| in_ready | output | 1 | Header will be taken this edge |
| hdr_kind | input | 8 | Header byte 0 (fmt and type) |
| hdr_dw2 | input | 32 | Header dword 2 (ID or address) |
| hdr_dw3 | input | 32 | Header dword 3 (low address of 64-bit form) |
| own_id | input | 16 | This port's bus/device/function |
| mem_base | input | 64 | Memory window low bound |
| mem_limit | input | 64 | Memory window high bound |
| io_base | input | 32 | I/O window low bound |
| io_limit | input | 32 | I/O window high bound |
| sec_bus | input | 8 | Secondary bus number |
| sub_bus | input | 8 | Subordinate bus number |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_scheme | output | 2 | Routing scheme |
| out_target | output | 2 | Destination |
| out_to_type0 | output | 1 | Convert forwarding config to local form |
| out_err | output | 1 | Unsupported type or message code |

## Verification
Random headers are drawn over every kind and all eight message codes. Their bus numbers are biased to `sec_bus-1`, `sec_bus`, `sec_bus+1`, `sub_bus`, `sub_bus+1` and `own_id`, and their addresses to each window bound and one past it. This separates the conversion case from plain forwarding, and the inclusive bounds from off-by-one errors. A second phase moves the memory window below 4 GiB, so that the 32-bit and 64-bit address forms are each seen both inside and outside the window. Random output stalls exercise the hold, pass and drain transitions of the output stage; back-to-back acceptance and stall-while-full are checked against the handshake rule.

// File: rtl/tlp_route_pkg.sv
package tlp_route_pkg;
    typedef enum logic [1:0] {
        SCH_ADDR     = 2'd0,
        SCH_ID       = 2'd1,
        SCH_IMPLICIT = 2'd2
    } scheme_e;

    typedef enum logic [1:0] {
        TGT_LOCAL = 2'd0,
        TGT_DOWN  = 2'd1,
        TGT_UP    = 2'd2,
        TGT_BCAST = 2'd3
    } target_e;

    typedef enum logic [2:0] {
        K_MEM, K_IO, K_CFG_LOCAL, K_CFG_FWD, K_CPL, K_MSG, K_BAD
    } kind_e;

    typedef enum logic [2:0] {
        MC_TO_ROOT  = 3'b000,
        MC_BY_ADDR  = 3'b001,
        MC_BY_ID    = 3'b010,
        MC_BCAST    = 3'b011,
        MC_LOCAL    = 3'b100,
        MC_GATHER   = 3'b101,
        MC_RSVD6    = 3'b110,
        MC_RSVD7    = 3'b111
    } msg_code_e;

    typedef struct packed {
        scheme_e scheme;
        target_e target;
        logic    to_type0;
        logic    err;
    } route_res_t;
endpackage

// File: rtl/trc_type_decode.sv
module trc_type_decode
    import tlp_route_pkg::*;
(
    input  logic [7:0] kind_byte,
    output kind_e      kind,
    output logic       wide_addr,
    output msg_code_e  msg_code
);
    always_comb begin
        wide_addr = kind_byte[5];
        msg_code  = msg_code_e'(kind_byte[2:0]);
        if (kind_byte[7]) begin
            kind = K_BAD;
        end else begin
            casez (kind_byte[4:0])
                5'b0000?: kind = K_MEM;
                5'b00010: kind = K_IO;
                5'b00100: kind = K_CFG_LOCAL;
                5'b00101: kind = K_CFG_FWD;
                5'b0101?: kind = K_CPL;
                5'b10???: kind = K_MSG;
                default:  kind = K_BAD;
            endcase
        end
    end
endmodule

// File: rtl/trc_window_match.sv
module trc_window_match #(
    parameter int W = 64
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         hit
);
    logic ge_lo;
    logic le_hi;
    assign ge_lo = (value >= lo);
    assign le_hi = (value <= hi);
    assign hit   = ge_lo && le_hi;
endmodule

// File: rtl/trc_id_match.sv
module trc_id_match #(
    parameter int ID_W  = 16,
    parameter int BUS_W = 8
) (
    input  logic [ID_W-1:0]  id,
    input  logic [ID_W-1:0]  own,
    input  logic [BUS_W-1:0] sec,
    input  logic [BUS_W-1:0] sub,
    output logic             is_self,
    output logic             bus_is_sec,
    output logic             bus_below_sec,
    output logic             bus_in_span
);
    logic [BUS_W-1:0] bus;
    assign bus           = id[ID_W-1 -: BUS_W];
    assign is_self       = (id == own);
    assign bus_is_sec    = (bus == sec);
    assign bus_below_sec = (bus > sec) && (bus <= sub);
    assign bus_in_span   = (bus >= sec) && (bus <= sub);
endmodule

// File: rtl/trc_route_fsm.sv
module trc_route_fsm
    import tlp_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  route_res_t res_in,
    output logic       out_valid,
    input  logic       out_ready,
    output route_res_t res_out
);
    typedef enum logic {ST_EMPTY = 1'b0, ST_FULL = 1'b1} state_e;

    state_e state_q;
    state_e state_d;
    logic   accept;

    assign in_ready  = (state_q == ST_EMPTY) || out_ready;
    assign accept    = in_valid && in_ready;
    assign out_valid = (state_q == ST_FULL);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;            // ACCEPT / IDLE
            ST_FULL:  if (out_ready && !accept) state_d = ST_EMPTY; // DRAIN / PASS / HOLD
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_out <= '{scheme: SCH_IMPLICIT, target: TGT_LOCAL, to_type0: 1'b0, err: 1'b0};
        end else if (accept) begin
            res_out <= res_in;
        end
    end
endmodule

// File: rtl/tlp_route_classifier.sv
module tlp_route_classifier
    import tlp_route_pkg::*;
#(
    parameter int DW_W  = 32,
    parameter int ID_W  = 16,
    parameter int BUS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        hdr_kind,
    input  logic [DW_W-1:0]   hdr_dw2,
    input  logic [DW_W-1:0]   hdr_dw3,
    input  logic [ID_W-1:0]   own_id,
    input  logic [2*DW_W-1:0] mem_base,
    input  logic [2*DW_W-1:0] mem_limit,
    input  logic [DW_W-1:0]   io_base,
    input  logic [DW_W-1:0]   io_limit,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_scheme,
    output logic [1:0]        out_target,
    output logic              out_to_type0,
    output logic              out_err
);
    localparam int ADDR_W = 2 * DW_W;

    kind_e             kind;
    logic              wide_addr;
    msg_code_e         msg_code;
    logic [ADDR_W-1:0] mem_addr;
    logic [ID_W-1:0]   tgt_id;
    logic              mem_hit;
    logic              io_hit;
    logic              id_self;
    logic              id_is_sec;
    logic              id_below_sec;
    logic              id_in_span;
    route_res_t        res_d;
    route_res_t        res_q;

    trc_type_decode u_dec (
        .kind_byte (hdr_kind),
        .kind      (kind),
        .wide_addr (wide_addr),
        .msg_code  (msg_code)
    );

    assign mem_addr = wide_addr ? {hdr_dw2, hdr_dw3} : {{DW_W{1'b0}}, hdr_dw2};
    assign tgt_id   = hdr_dw2[DW_W-1 -: ID_W];

    trc_window_match #(.W(ADDR_W)) u_mem_win (
        .value (mem_addr),
        .lo    (mem_base),
        .hi    (mem_limit),
        .hit   (mem_hit)
    );

    trc_window_match #(.W(DW_W)) u_io_win (
        .value (hdr_dw2),
        .lo    (io_base),
        .hi    (io_limit),
        .hit   (io_hit)
    );

    trc_id_match #(.ID_W(ID_W), .BUS_W(BUS_W)) u_id (
        .id            (tgt_id),
        .own           (own_id),
        .sec           (sec_bus),
        .sub           (sub_bus),
        .is_self       (id_self),
        .bus_is_sec    (id_is_sec),
        .bus_below_sec (id_below_sec),
        .bus_in_span   (id_in_span)
    );

    function automatic route_res_t by_id(input logic self, input logic span);
        route_res_t r;
        r = '{scheme: SCH_ID, target: TGT_UP, to_type0: 1'b0, err: 1'b0};
        if (self)      r.target = TGT_LOCAL;
        else if (span) r.target = TGT_DOWN;
        return r;
    endfunction

    function automatic route_res_t by_addr(input logic hit);
        route_res_t r;
        r = '{scheme: SCH_ADDR, target: (hit ? TGT_DOWN : TGT_UP), to_type0: 1'b0, err: 1'b0};
        return r;
    endfunction

    always_comb begin
        res_d = '{scheme: SCH_IMPLICIT, target: TGT_LOCAL, to_type0: 1'b0, err: 1'b0};
        unique case (kind)
            K_MEM:       res_d = by_addr(mem_hit);
            K_IO:        res_d = by_addr(io_hit);
            K_CFG_LOCAL: res_d.scheme = SCH_ID;
            K_CFG_FWD: begin
                res_d.scheme = SCH_ID;
                if (id_is_sec) begin
                    res_d.target   = TGT_DOWN;
                    res_d.to_type0 = 1'b1;
                end else if (id_below_sec) begin
                    res_d.target = TGT_DOWN;
                end else begin
                    res_d.target = TGT_UP;
                end
            end
            K_CPL:       res_d = by_id(id_self, id_in_span);
            K_MSG: begin
                unique case (msg_code)
                    MC_TO_ROOT: res_d.target = TGT_UP;
                    MC_BY_ADDR: res_d = by_addr(mem_hit);
                    MC_BY_ID:   res_d = by_id(id_self, id_in_span);
                    MC_BCAST:   res_d.target = TGT_BCAST;
                    MC_LOCAL:   res_d.target = TGT_LOCAL;
                    MC_GATHER:  res_d.target = TGT_UP;
                    MC_RSVD6,
                    MC_RSVD7:   res_d.err = 1'b1;
                    default:    res_d.err = 1'b1;
                endcase
            end
            K_BAD:       res_d.err = 1'b1;
            default:     res_d.err = 1'b1;
        endcase
    end

    trc_route_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .res_in    (res_d),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .res_out   (res_q)
    );

    assign out_scheme   = res_q.scheme;
    assign out_target   = res_q.target;
    assign out_to_type0 = res_q.to_type0;
    assign out_err      = res_q.err;
endmodule

// File: rtl/trc_checker.sv
module trc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [1:0] out_scheme,
    input logic [1:0] out_target,
    input logic       out_to_type0,
    input logic       out_err
);
    AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1
    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> out_valid); // R2
    AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> in_ready); // R2
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=>
        (out_valid && $stable(out_scheme) && $stable(out_target) && $stable(out_to_type0) && $stable(out_err))); // R2
    AST_CVT_DOWN_ID: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_to_type0) |->
        (out_target == 2'd1 && out_scheme == 2'd1)); // R6
    AST_BCAST_IMPLICIT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_target == 2'd3) |->
        (out_scheme == 2'd2)); // R8
    AST_ERR_LOCAL: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_err) |->
        (out_target == 2'd0 && out_scheme == 2'd2 && !out_to_type0)); // R10
    AST_SCHEME_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_scheme != 2'd3)); // R2
endmodule

bind tlp_route_classifier trc_checker u_trc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_scheme   (out_scheme),
    .out_target   (out_target),
    .out_to_type0 (out_to_type0),
    .out_err      (out_err)
);

// File: tb/tb_tlp_route_classifier.sv
`timescale 1ns/1ps
module tb_tlp_route_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  hdr_kind = 8'h0;
    logic [31:0] hdr_dw2 = '0;
    logic [31:0] hdr_dw3 = '0;
    logic [15:0] own_id;
    logic [63:0] mem_base, mem_limit;
    logic [31:0] io_base, io_limit;
    logic [7:0]  sec_bus, sub_bus;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [1:0]  out_scheme, out_target;
    logic        out_to_type0, out_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tlp_route_classifier dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .hdr_kind(hdr_kind), .hdr_dw2(hdr_dw2), .hdr_dw3(hdr_dw3),
        .own_id(own_id), .mem_base(mem_base), .mem_limit(mem_limit),
        .io_base(io_base), .io_limit(io_limit), .sec_bus(sec_bus), .sub_bus(sub_bus),
        .out_valid(out_valid), .out_ready(out_ready), .out_scheme(out_scheme),
        .out_target(out_target), .out_to_type0(out_to_type0), .out_err(out_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected result {scheme[1:0], target[1:0], to_type0, err} per the requirements.
    function automatic logic [5:0] mem_rule(input logic [7:0] k, input logic [31:0] d2, input logic [31:0] d3);
        logic [63:0] a;
        a = k[5] ? {d2, d3} : {32'h0, d2};
        return {2'd0, (a >= mem_base && a <= mem_limit) ? 2'd1 : 2'd2, 2'b00};
    endfunction

    function automatic logic [5:0] cpl_rule(input logic [31:0] d2);
        logic [7:0] b;
        b = d2[31:24];
        if (d2[31:16] == own_id)             return {2'd1, 2'd0, 2'b00};
        else if (b >= sec_bus && b <= sub_bus) return {2'd1, 2'd1, 2'b00};
        else                                  return {2'd1, 2'd2, 2'b00};
    endfunction

    function automatic logic [5:0] model(input logic [7:0] k, input logic [31:0] d2, input logic [31:0] d3,
                                         output string req);
        logic [7:0] b;
        b = d2[31:24];
        req = "R10";
        if (k[7]) return {2'd2, 2'd0, 2'b01};
        if (k[4:1] == 4'b0000) begin req = "R3"; return mem_rule(k, d2, d3); end
        if (k[4:0] == 5'b00010) begin
            req = "R4";
            return {2'd0, (d2 >= io_base && d2 <= io_limit) ? 2'd1 : 2'd2, 2'b00};
        end
        if (k[4:0] == 5'b00100) begin req = "R5"; return {2'd1, 2'd0, 2'b00}; end
        if (k[4:0] == 5'b00101) begin
            req = "R6";
            if (b == sec_bus)                   return {2'd1, 2'd1, 2'b10};
            else if (b > sec_bus && b <= sub_bus) return {2'd1, 2'd1, 2'b00};
            else                                return {2'd1, 2'd2, 2'b00};
        end
        if (k[4:1] == 4'b0101) begin req = "R7"; return cpl_rule(d2); end
        if (k[4:3] == 2'b10) begin
            case (k[2:0])
                3'b000: begin req = "R8"; return {2'd2, 2'd2, 2'b00}; end
                3'b001: begin req = "R9"; return mem_rule(k, d2, d3); end
                3'b010: begin req = "R9"; return cpl_rule(d2); end
                3'b011: begin req = "R8"; return {2'd2, 2'd3, 2'b00}; end
                3'b100: begin req = "R8"; return {2'd2, 2'd0, 2'b00}; end
                3'b101: begin req = "R8"; return {2'd2, 2'd2, 2'b00}; end
                default: return {2'd2, 2'd0, 2'b01};
            endcase
        end
        return {2'd2, 2'd0, 2'b01};
    endfunction

    function automatic logic [7:0] pick_bus();
        case ($urandom_range(0, 6))
            0: return sec_bus - 8'd1;
            1: return sec_bus;
            2: return sec_bus + 8'd1;
            3: return sub_bus;
            4: return sub_bus + 8'd1;
            5: return own_id[15:8];
            default: return 8'($urandom);
        endcase
    endfunction

    function automatic logic [63:0] pick_addr(input logic [63:0] lo, input logic [63:0] hi);
        case ($urandom_range(0, 5))
            0: return lo;
            1: return lo - 64'd1;
            2: return hi;
            3: return hi + 64'd1;
            4: return lo + 64'd5;
            default: return {32'($urandom), 32'($urandom)};
        endcase
    endfunction

    task automatic new_header();
        logic [7:0]  k;
        logic [63:0] a;
        logic [2:0]  fmt;
        fmt = {1'b0, 2'($urandom)};
        case ($urandom_range(0, 9))
            0, 1: k = {fmt, 4'b0000, 1'($urandom)};
            2:    k = {fmt, 5'b00010};
            3:    k = {fmt, 5'b00100};
            4:    k = {fmt, 5'b00101};
            5:    k = {fmt, 4'b0101, 1'($urandom)};
            6, 7: k = {fmt, 2'b10, 3'($urandom)};
            8:    k = {1'b1, 7'($urandom)};
            default: k = 8'($urandom);
        endcase
        hdr_kind = k;
        if (k[4:0] == 5'b00010) begin
            a = pick_addr({32'h0, io_base}, {32'h0, io_limit});
            hdr_dw2 = a[31:0];
            hdr_dw3 = 32'($urandom);
        end else if (k[4:1] == 4'b0000 || k[4:0] == 5'b10001) begin
            a = pick_addr(mem_base, mem_limit);
            if (k[5]) begin hdr_dw2 = a[63:32]; hdr_dw3 = a[31:0]; end
            else begin hdr_dw2 = a[31:0]; hdr_dw3 = 32'($urandom); end
        end else begin
            hdr_dw2 = ($urandom_range(0, 3) == 0) ? {own_id, 16'($urandom)}
                                                  : {pick_bus(), 24'($urandom)};
            hdr_dw3 = 32'($urandom);
        end
    endtask

    logic [5:0] exp_q[$];
    string      req_q[$];

    initial begin
        automatic int seed = 32'h1234_5a5a;
        automatic bit acc_prev = 0;
        automatic bit stall_prev = 0;
        automatic logic [5:0] prev_out = '0;
        automatic string r;
        automatic logic [5:0] e;
        void'($urandom(seed));
        own_id = 16'h1408; sec_bus = 8'h10; sub_bus = 8'h1F;
        mem_base = 64'h0000_0001_0000_0000; mem_limit = 64'h0000_0001_FFFF_FFFF;
        io_base = 32'h0000_1000; io_limit = 32'h0000_1FFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 out_valid", 32'(out_valid), 0);
        check("R1 in_ready", 32'(in_ready), 1);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            if (cyc == 2000) begin
                mem_base = 64'h0000_0000_8000_0000; mem_limit = 64'h0000_0000_8FFF_FFFF;
                sec_bus = 8'h40; sub_bus = 8'h47; own_id = 16'h3F10;
            end
            out_ready = ($urandom_range(0, 3) != 0);
            if (!(in_valid && !in_ready)) begin
                in_valid = ($urandom_range(0, 4) != 0);
                if (in_valid) new_header();
            end
            #1;
            if (acc_prev) check("R2 result after accept", 32'(out_valid), 1);
            if (stall_prev) begin
                check("R2 stable while stalled",
                      32'({out_valid, out_scheme, out_target, out_to_type0, out_err}), 32'({1'b1, prev_out}));
            end
            check("R2 ready rule", 32'(in_ready), 32'(!out_valid || out_ready));
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected result", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    check(r, 32'({out_scheme, out_target, out_to_type0, out_err}), 32'(e));
                end
            end
            stall_prev = out_valid && !out_ready;
            prev_out = {out_scheme, out_target, out_to_type0, out_err};
            acc_prev = in_valid && in_ready;
            if (acc_prev) begin
                e = model(hdr_kind, hdr_dw2, hdr_dw3, r);
                exp_q.push_back(e);
                req_q.push_back(r);
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule